// File: doc/BRIEF.md
# Half-Group Load/Store Coalescer

This block sits between a lane-parallel load/store unit and the memory request path. It takes one request for a group of 16 lanes. Every lane brings an enable bit and a byte address, and the whole group shares one word size. The block checks whether the group can be folded into a few wide, aligned memory transactions. If it can, it sends those. If it cannot, it sends one transaction per enabled lane, one after another. The block emits only addresses and sizes. Data movement and the memory array belong to other blocks.

Requests arrive on a valid/ready port. A group is taken when `req_valid` and `req_ready` are both high at a clock edge. Transactions leave on a second valid/ready port, one beat per transaction. The sink may hold `txn_ready` low for as long as it likes. While it does, the current beat stays on the port without any change. `txn_last` marks the final beat of a group. `req_ready` stays low from the moment a group is taken until that final beat has been handed off. This gives exactly one group in flight, with no queue on either side.

Top module: `coalescer`

## Requirements
- R1: `req_size` selects the word size W as follows: code 0 is 4 bytes, code 1 is 8 bytes, and codes 2 and 3 are 16 bytes. Lane k's address is `req_addr[32*k +: 32]` and its enable is `req_active[k]`.
- R2: A qualifying group of 4-byte words produces exactly one 64-byte transaction at the segment base, with `txn_last` set.
- R3: A qualifying group of 8-byte words produces exactly one 128-byte transaction at the segment base, with `txn_last` set.
- R4: A qualifying group of 16-byte words produces two 128-byte transactions. The first is at the segment base and the second at base+128. Only the second carries `txn_last`.
- R5: A group qualifies when at least one lane is enabled and there is an S aligned to 16·W such that every enabled lane k has address S + k·W. The addresses of disabled lanes are ignored.
- R6: A group with enabled lanes that does not qualify produces one transaction per enabled lane, in ascending lane order. Each transaction is W bytes at that lane's address, and only the final one carries `txn_last`.
- R7: A group with no enabled lanes is accepted, produces no transaction, and leaves `req_ready` high.
- R8: `req_ready` is low while a group's transactions are outstanding. In the cycle after the last beat's handshake, `txn_valid` is low and `req_ready` is high.
- R9: While `txn_valid` is high and `txn_ready` is low, the beat (`txn_addr`, `txn_bytes`, `txn_last`) is held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request group offered |
| req_ready | output | 1 | Coalescer can take a group |
| req_size | input | 2 | Word size code |
| req_active | input | 16 | Per-lane enable |
| req_addr | input | 512 | Per-lane byte address, lane k at bits 32k+31:32k |
| txn_valid | output | 1 | Transaction beat offered |
| txn_ready | input | 1 | Sink takes the beat |
| txn_addr | output | 32 | Transaction byte address |
| txn_bytes | output | 8 | Transaction length in bytes |
| txn_last | output | 1 | Final beat of the group |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-group-in-flight rule, the release after the last beat, the stability of a stalled beat, the alignment of merged beats to their length, the rule that a fallback beat always comes from a still-pending lane, and the silence after an empty group. Other behaviour can only be shown by the bench's scenarios. This includes whether a given address pattern merges or falls back, the exact address and byte count of each beat, the lane order of fallback beats, and the handling of code 3 and of garbage addresses on disabled lanes.

// File: rtl/cx_pkg.sv
package cx_pkg;

  // log2 of the word size in bytes for a size code (codes 2 and 3 both give 16 bytes)
  function automatic int unsigned word_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2;
      2'd1:    return 3;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/cx_match.sv
module cx_match
  import cx_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    active,
  input  logic [LANES*AW-1:0] addr,
  input  logic [1:0]          size,
  output logic                merge,
  output logic                any_active,
  output logic [AW-1:0]       seg_base
);
  localparam int LG = $clog2(LANES);

  logic [AW-1:0]    seg_mask;
  logic [AW-1:0]    ref_hi;
  logic [LANES-1:0] lane_ok;

  // segment covers all lanes' words: LANES * W bytes
  always_comb begin
    seg_mask = (AW'(1) << (word_shift(size) + LG)) - AW'(1);
  end

  // segment of the lowest enabled lane is the reference
  always_comb begin
    ref_hi = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (active[k]) ref_hi = addr[k*AW +: AW] & ~seg_mask;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] a;
    assign a = addr[k*AW +: AW];
    assign lane_ok[k] = !active[k] ||
                        (((a & ~seg_mask) == ref_hi) &&
                         ((a & seg_mask) == (AW'(k) << word_shift(size))));
  end

  assign any_active = |active;
  assign merge      = any_active && (&lane_ok);
  assign seg_base   = ref_hi;

endmodule

// File: rtl/cx_pick.sv
module cx_pick #(
  parameter int LANES = 16,
  localparam int IW   = $clog2(LANES)
) (
  input  logic [LANES-1:0] pending,
  output logic [IW-1:0]    idx,
  output logic [LANES-1:0] onehot,
  output logic             single
);
  always_comb begin
    idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (pending[k]) idx = IW'(k);
    end
  end

  assign onehot = pending & (~pending + LANES'(1));
  assign single = (pending != '0) && ((pending & (pending - LANES'(1))) == '0);

endmodule

// File: rtl/cx_beat.sv
module cx_beat
  import cx_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int AW      = 32,
  parameter int MAX_TXN = 128,
  parameter int BCW     = 2,
  localparam int BW     = $clog2(MAX_TXN) + 1
) (
  input  logic           merged,
  input  logic [1:0]     size,
  input  logic [AW-1:0]  seg_base,
  input  logic [BCW-1:0] beat,
  input  logic [AW-1:0]  lane_addr,
  input  logic           lane_single,
  output logic [AW-1:0]  addr,
  output logic [BW-1:0]  bytes,
  output logic           last
);
  localparam int LG     = $clog2(LANES);
  localparam int MAX_SH = $clog2(MAX_TXN);

  int unsigned seg_sh;
  int unsigned txn_sh;
  int unsigned n_beats;

  always_comb begin
    seg_sh  = word_shift(size) + LG;
    txn_sh  = (seg_sh > MAX_SH) ? MAX_SH : seg_sh;
    n_beats = 32'd1 << (seg_sh - txn_sh);
    if (merged) begin
      addr  = seg_base + (AW'(beat) << txn_sh);
      bytes = BW'(1) << txn_sh;
      last  = (32'(beat) == n_beats - 32'd1);
    end else begin
      addr  = lane_addr;
      bytes = BW'(1) << word_shift(size);
      last  = lane_single;
    end
  end

endmodule

// File: rtl/coalescer.sv
module coalescer #(
  parameter int LANES   = 16,
  parameter int AW      = 32,
  parameter int MAX_TXN = 128,
  localparam int BW     = $clog2(MAX_TXN) + 1,
  localparam int IW     = $clog2(LANES),
  localparam int MAXB   = (LANES * 16 > MAX_TXN) ? (LANES * 16 / MAX_TXN) : 1,
  localparam int BCW    = $clog2(MAXB + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_size,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_addr,
  output logic [BW-1:0]       txn_bytes,
  output logic                txn_last
);
  logic                merge_now, any_now;
  logic [AW-1:0]       seg_now;

  logic                st_busy, st_merged;
  logic [1:0]          st_size;
  logic [AW-1:0]       st_seg;
  logic [LANES-1:0]    st_mask;
  logic [LANES*AW-1:0] st_addr;
  logic [BCW-1:0]      st_beat;

  logic [IW-1:0]       pick_idx;
  logic [LANES-1:0]    pick_onehot;
  logic                pick_single;
  logic [AW-1:0]       lane_addr;
  logic                take, fire;

  cx_match #(.LANES(LANES), .AW(AW)) u_match (
    .active     (req_active),
    .addr       (req_addr),
    .size       (req_size),
    .merge      (merge_now),
    .any_active (any_now),
    .seg_base   (seg_now)
  );

  cx_pick #(.LANES(LANES)) u_pick (
    .pending (st_mask),
    .idx     (pick_idx),
    .onehot  (pick_onehot),
    .single  (pick_single)
  );

  assign lane_addr = st_addr[int'(pick_idx)*AW +: AW];

  cx_beat #(.LANES(LANES), .AW(AW), .MAX_TXN(MAX_TXN), .BCW(BCW)) u_beat (
    .merged      (st_merged),
    .size        (st_size),
    .seg_base    (st_seg),
    .beat        (st_beat),
    .lane_addr   (lane_addr),
    .lane_single (pick_single),
    .addr        (txn_addr),
    .bytes       (txn_bytes),
    .last        (txn_last)
  );

  assign req_ready = !st_busy;
  assign txn_valid = st_busy;
  assign take      = req_valid && req_ready;
  assign fire      = txn_valid && txn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_busy   <= 1'b0;
      st_merged <= 1'b0;
      st_size   <= '0;
      st_seg    <= '0;
      st_mask   <= '0;
      st_addr   <= '0;
      st_beat   <= '0;
    end else if (take) begin
      st_busy   <= any_now;
      st_merged <= merge_now;
      st_size   <= req_size;
      st_seg    <= seg_now;
      st_mask   <= req_active;
      st_addr   <= req_addr;
      st_beat   <= '0;
    end else if (fire) begin
      if (txn_last)       st_busy <= 1'b0;
      else if (st_merged) st_beat <= st_beat + BCW'(1);
      else                st_mask <= st_mask & ~pick_onehot;
    end
  end

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready); // R8
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    fire && txn_last |=> !txn_valid && req_ready); // R8
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_bytes) && $stable(txn_last)); // R9
  AST_MERGED_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && st_merged |-> (txn_addr & (AW'(txn_bytes) - AW'(1))) == '0); // R5
  AST_PICK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !st_merged |-> st_mask[pick_idx]); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    take && (req_active == '0) |=> !txn_valid); // R7

endmodule

// File: tb/coalescer_test.sv
`timescale 1ns/1ps
module coalescer_test;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [1:0]          req_size = '0;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                txn_valid;
  logic                txn_ready = 1'b1;
  logic [AW-1:0]       txn_addr;
  logic [7:0]          txn_bytes;
  logic                txn_last;

  always #10 clk = ~clk;

  coalescer uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_active(req_active), .req_addr(req_addr),
    .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_bytes(txn_bytes), .txn_last(txn_last)
  );

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  logic [AW-1:0] exp_a [LANES];
  int            exp_b [LANES];
  int            exp_n;

  // {size, active mask, base, stride}
  localparam logic [81:0] VEC [0:10] = '{
    {2'd0, 16'hFFFF, 32'h0000_1000, 32'd4},
    {2'd1, 16'hFFFF, 32'h0000_2080, 32'd8},
    {2'd2, 16'hFFFF, 32'h0000_3100, 32'd16},
    {2'd0, 16'h5A5A, 32'h0000_0040, 32'd4},
    {2'd0, 16'hFFFF, 32'h0000_1004, 32'd4},
    {2'd0, 16'hFFFF, 32'h0000_0000, 32'd8},
    {2'd2, 16'hFFFF, 32'h0000_3080, 32'd16},
    {2'd1, 16'h0003, 32'h0000_0500, 32'd8},
    {2'd0, 16'h0000, 32'h0000_0000, 32'd4},
    {2'd3, 16'hFFFF, 32'h0000_4000, 32'd16},
    {2'd1, 16'h8001, 32'h0000_0600, 32'd8}
  };
  string VREQ [0:10] = '{"R2", "R3", "R4", "R5", "R6", "R6", "R6", "R3", "R7", "R1", "R5"};

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  function automatic logic [LANES*AW-1:0] ramp(input logic [31:0] base, input logic [31:0] stride);
    logic [LANES*AW-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*AW +: AW] = base + stride * k;
    return v;
  endfunction

  task automatic model(input logic [1:0] sz, input logic [15:0] m, input logic [LANES*AW-1:0] a);
    int w;
    int seg;
    logic [31:0] refv;
    logic [31:0] lane;
    bit have;
    bit ok;
    w = (sz == 2'd0) ? 4 : (sz == 2'd1) ? 8 : 16;
    seg = w * 16;
    have = 0;
    ok = 1;
    refv = '0;
    exp_n = 0;
    for (int k = 0; k < LANES; k++) begin
      if (m[k]) begin
        lane = a[k*AW +: AW];
        if (!have) refv = lane - (lane % seg) ;
        have = 1;
        if (lane != refv + w * k) ok = 0;
      end
    end
    if (!have) begin
      exp_n = 0;
    end else if (ok && seg <= 128) begin
      exp_a[0] = refv; exp_b[0] = seg; exp_n = 1;
    end else if (ok) begin
      exp_a[0] = refv; exp_b[0] = 128;
      exp_a[1] = refv + 128; exp_b[1] = 128; exp_n = 2;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (m[k]) begin
          exp_a[exp_n] = a[k*AW +: AW];
          exp_b[exp_n] = w;
          exp_n++;
        end
      end
    end
  endtask

  task automatic run(input logic [1:0] sz, input logic [15:0] m,
                     input logic [LANES*AW-1:0] a, input bit stall, input string rq);
    int got;
    int cyc;
    bit done;
    bit pend;
    logic [AW-1:0] pa;
    got = 0; cyc = 0; done = 0; pend = 0; pa = '0;
    model(sz, m, a);
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready before group", req_ready, 1);
    req_valid = 1'b1; req_size = sz; req_active = m; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_n == 0) begin
      check(txn_valid == 1'b0, "R7", "no beat for empty group", txn_valid, 0);
      check(req_ready == 1'b1, "R7", "ready after empty group", req_ready, 1);
      return;
    end
    while (!done && cyc < 80) begin
      if (pend) check(txn_valid && txn_addr == pa, "R9", "stalled beat held", txn_addr, pa);
      txn_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (txn_valid) check(req_ready == 1'b0, "R8", "busy blocks request", req_ready, 0);
      if (txn_valid && txn_ready) begin
        if (got < exp_n) begin
          check(txn_addr == exp_a[got], rq, "beat address", txn_addr, exp_a[got]);
          check(int'(txn_bytes) == exp_b[got], rq, "beat bytes", txn_bytes, exp_b[got]);
          check(txn_last == (got == exp_n - 1), rq, "beat last flag", txn_last, (got == exp_n - 1));
        end
        got++;
        if (txn_last) done = 1;
        pend = 0;
      end else begin
        pend = txn_valid;
      end
      pa = txn_addr;
      @(negedge clk);
      cyc++;
    end
    txn_ready = 1'b1;
    check(got == exp_n, rq, "beat count", got, exp_n);
    check(!txn_valid && req_ready, "R8", "released after last beat", {txn_valid, req_ready}, 2'b01);
  endtask

  initial begin
    logic [LANES*AW-1:0] a;
    @(negedge clk);
    check(txn_valid == 1'b0 && req_ready == 1'b1, "R8", "reset state", {txn_valid, req_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i <= 10; i++) begin
      run(VEC[i][81:80], VEC[i][79:64], ramp(VEC[i][63:32], VEC[i][31:0]), 1'b0, VREQ[i]);
    end

    // R9: back-pressure on a fallback group and on a two-beat merged group
    run(2'd0, 16'hFFFF, ramp(32'h1004, 32'd4), 1'b1, "R9");
    run(2'd2, 16'hFFFF, ramp(32'h3100, 32'd16), 1'b1, "R9");

    // R6: lanes 1 and 2 swapped
    a = ramp(32'h800, 32'd4);
    a[1*AW +: AW] = 32'h808;
    a[2*AW +: AW] = 32'h804;
    run(2'd0, 16'hFFFF, a, 1'b0, "R6");

    // R5: disabled lane 0 carries garbage, group still merges
    a = ramp(32'h900, 32'd4);
    a[0 +: AW] = 32'hDEAD_0000;
    run(2'd0, 16'hFFFE, a, 1'b0, "R5");

    // R6: lane 15 in the next segment with the right offset
    a = ramp(32'hA00, 32'd4);
    a[15*AW +: AW] = 32'hA00 + 32'd64 + 32'd60;
    run(2'd0, 16'hFFFF, a, 1'b0, "R6");

    // R6: partially enabled fallback in lane order
    run(2'd1, 16'h0A05, ramp(32'hB04, 32'd8), 1'b0, "R6");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule